// File: doc/BRIEF.md
# Quadrature Position Counter with Index Reload

This block turns a two-phase incremental encoder signal into a position count. It also takes the encoder's once-per-revolution index pulse. Every transition on either phase is counted, which gives four counts per line cycle. The direction of the last valid transition is reported. A transition in which both phases change at once is illegal. It sets a sticky error flag and leaves the count unchanged. Outside index handling, the count runs from zero to a programmable maximum and wraps at both ends.

Two index modes are provided.

- **Index-reset mode:** the first valid transition seen while the index is high is an index event. The block records which physical edge of the quadrature cycle that was, meaning the edge between two particular phase states. After that, only a crossing of that same edge while the index is high reloads the counter. A forward crossing loads zero. A reverse crossing loads the maximum.
- **Index-initialization mode:** a rising edge of the index loads a programmed initialization value.

In both modes the first index event sets a sticky flag and captures the direction. The A, B and index inputs are expected to be already synchronized to `clk`.

Top module: `qpos_counter`

## Requirements
- R1: A synchronous active-high reset clears the count, the direction (0), the stored first-index edge, the first-index flag, the first-index direction and the phase-error flag. During reset the current A/B state is taken as the reference state.
- R2: Phase states map to positions as AB=00→0, 01→1, 11→2, 10→3. A step of +1 in that order is a forward edge: the count increments and `dir_fwd` becomes 1. A step of −1 is a reverse edge: the count decrements and `dir_fwd` becomes 0. With no change, count and direction hold. Outputs update on the clock edge that samples the new inputs.
- R3: Counting up from `pos_max` gives 0. Counting down from 0 gives `pos_max`.
- R4: A step of two positions (both phases changing together) sets `phase_err`. The flag stays set until reset. Count and direction are left unchanged.
- R5: In index-reset mode (`idx_mode`=0), a qualifying index event on a forward edge sets the count to 0.
- R6: In index-reset mode, a qualifying index event on a reverse edge sets the count to `pos_max`.
- R7: The first index event sets `first_idx_seen`, which stays set until reset. It also captures into `first_idx_dir` the direction of that cycle's edge, or the current direction if that cycle has no valid edge.
- R8: In index-reset mode, the first index event stores the physical edge crossed. This is the lower position for a forward edge and the destination position for a reverse edge. Later reloads happen only when the index is high and that same edge is crossed. Other edges count normally even while the index is high.
- R9: If the direction reverses while the index is still high, crossing back over the stored edge loads `pos_max`, which continues the count from 0 by exactly one. Crossing any other edge changes the count by one only. The count never jumps.
- R10: In index-initialization mode (`idx_mode`=1), a rising edge of the index loads `pos_init` in place of any count change in that cycle. A high level held on later cycles loads nothing more, and no edge qualification applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enc_a | input | 1 | Phase A, synchronized |
| enc_b | input | 1 | Phase B, synchronized |
| enc_idx | input | 1 | Index pulse, synchronized |
| idx_mode | input | 1 | 0 = index reset, 1 = index initialization |
| pos_max | input | CNT_W | Highest count value before wrap |
| pos_init | input | CNT_W | Value loaded on an index event in mode 1 |
| pos_cnt | output | CNT_W | Position count |
| dir_fwd | output | 1 | 1 when the last valid edge was forward |
| first_idx_seen | output | 1 | Sticky: first index event occurred |
| first_idx_dir | output | 1 | Direction at the first index event |
| phase_err | output | 1 | Sticky: illegal double-phase change seen |

## Verification
The main target is a direction reversal while the index is held high. Directed sequences cross the stored edge forward and then back. A design that ignores the new direction would reset to 0 a second time, or skip the reload, and the count would jump by several counts. Crossings of other edges under a high index catch a design that reloads on any edge. An initial approach in reverse must load the maximum, not decrement. In initialization mode, a held index must load only once. Random walks with reversals, index windows and illegal steps are compared cycle by cycle against a bench model of the requirements.

// File: rtl/qpos_pkg.sv
package qpos_pkg;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_FWD  = 2'd1,
    STEP_ILL  = 2'd2,
    STEP_REV  = 2'd3
  } step_e;

  typedef enum logic {
    MODE_IDX_RESET = 1'b0,
    MODE_IDX_INIT  = 1'b1
  } idx_mode_e;

  // Position of a phase state inside the quadrature cycle.
  function automatic logic [1:0] phase_pos(input logic [1:0] ab);
    logic [1:0] p;
    case (ab)
      2'b00:   p = 2'd0;
      2'b01:   p = 2'd1;
      2'b11:   p = 2'd2;
      default: p = 2'd3;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/qpos_phase_dec.sv
module qpos_phase_dec
  import qpos_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] ab_in,
  output step_e      step,
  output logic [1:0] edge_id,
  output logic       phase_err
);

  logic [1:0] ab_q;
  logic [1:0] p_prev;
  logic [1:0] p_cur;
  logic [1:0] delta;

  always_comb begin
    p_prev  = phase_pos(ab_q);
    p_cur   = phase_pos(ab_in);
    delta   = p_cur - p_prev;
    step    = step_e'(delta);
    // Physical edge: lower position of the pair that was crossed.
    edge_id = (delta == 2'd1) ? p_prev : p_cur;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ab_q      <= ab_in;
      phase_err <= 1'b0;
    end else begin
      ab_q <= ab_in;
      if (step == STEP_ILL) phase_err <= 1'b1;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    phase_err |=> phase_err); // R4

  AST_ILL_BOTH_PHASES: assert property (@(posedge clk) disable iff (rst)
    (step == STEP_ILL) |-> (ab_in == ~ab_q)); // R4

endmodule

// File: rtl/qpos_index_qual.sv
module qpos_index_qual
  import qpos_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  idx_mode_e  mode,
  input  logic       idx,
  input  step_e      step,
  input  logic [1:0] edge_id,
  input  logic       dir_q,
  output logic       ld_zero,
  output logic       ld_max,
  output logic       ld_init,
  output logic       first_seen,
  output logic       first_dir
);

  logic       idx_q;
  logic [1:0] first_edge;
  logic       valid_edge;
  logic       fwd_edge;
  logic       evt;

  always_comb begin
    valid_edge = (step == STEP_FWD) || (step == STEP_REV);
    fwd_edge   = (step == STEP_FWD);
    if (mode == MODE_IDX_RESET)
      evt = idx && valid_edge && (!first_seen || (edge_id == first_edge));
    else
      evt = idx && !idx_q;
    ld_zero = (mode == MODE_IDX_RESET) && evt && fwd_edge;
    ld_max  = (mode == MODE_IDX_RESET) && evt && !fwd_edge;
    ld_init = (mode == MODE_IDX_INIT)  && evt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q      <= 1'b0;
      first_seen <= 1'b0;
      first_dir  <= 1'b0;
      first_edge <= 2'd0;
    end else begin
      idx_q <= idx;
      if (evt && !first_seen) begin
        first_seen <= 1'b1;
        first_dir  <= valid_edge ? fwd_edge : dir_q;
        first_edge <= edge_id;
      end
    end
  end

  AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ld_zero, ld_max, ld_init})); // R10

  AST_FIRST_STICKY: assert property (@(posedge clk) disable iff (rst)
    first_seen |=> first_seen); // R7

  AST_RELOAD_NEEDS_IDX: assert property (@(posedge clk) disable iff (rst)
    (ld_zero || ld_max) |-> (idx && valid_edge)); // R8

  AST_INIT_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    ld_init |=> !ld_init); // R10

endmodule

// File: rtl/qpos_count_core.sv
module qpos_count_core
  import qpos_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  step_e            step,
  input  logic             ld_zero,
  input  logic             ld_max,
  input  logic             ld_init,
  input  logic [CNT_W-1:0] pos_max,
  input  logic [CNT_W-1:0] pos_init,
  output logic [CNT_W-1:0] cnt,
  output logic             dir
);

  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic ld_any;
  assign ld_any = ld_zero || ld_max || ld_init;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= CNT_ZERO;
      dir <= 1'b0;
    end else begin
      if (step == STEP_FWD) dir <= 1'b1;
      else if (step == STEP_REV) dir <= 1'b0;

      if (ld_init)      cnt <= pos_init;
      else if (ld_zero) cnt <= CNT_ZERO;
      else if (ld_max)  cnt <= pos_max;
      else begin
        case (step)
          STEP_FWD: cnt <= (cnt == pos_max) ? CNT_ZERO : cnt + CNT_ONE;
          STEP_REV: cnt <= (cnt == CNT_ZERO) ? pos_max : cnt - CNT_ONE;
          default:  cnt <= cnt;
        endcase
      end
    end
  end

  AST_FWD_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step == STEP_FWD && !ld_any && cnt == pos_max) |=> (cnt == CNT_ZERO)); // R3

  AST_REV_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step == STEP_REV && !ld_any && cnt == CNT_ZERO) |=> (cnt == $past(pos_max))); // R3

  AST_ILL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (step == STEP_ILL && !ld_any) |=> ($stable(cnt) && $stable(dir))); // R4

  AST_LOAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    ld_zero |=> (cnt == CNT_ZERO)); // R5

  AST_LOAD_MAX: assert property (@(posedge clk) disable iff (rst)
    ld_max |=> (cnt == $past(pos_max))); // R6

endmodule

// File: rtl/qpos_counter.sv
module qpos_counter
  import qpos_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic             enc_idx,
  input  logic             idx_mode,
  input  logic [CNT_W-1:0] pos_max,
  input  logic [CNT_W-1:0] pos_init,
  output logic [CNT_W-1:0] pos_cnt,
  output logic             dir_fwd,
  output logic             first_idx_seen,
  output logic             first_idx_dir,
  output logic             phase_err
);

  step_e      step;
  logic [1:0] edge_id;
  logic       ld_zero;
  logic       ld_max;
  logic       ld_init;

  qpos_phase_dec u_dec (
    .clk       (clk),
    .rst       (rst),
    .ab_in     ({enc_a, enc_b}),
    .step      (step),
    .edge_id   (edge_id),
    .phase_err (phase_err)
  );

  qpos_index_qual u_idx (
    .clk        (clk),
    .rst        (rst),
    .mode       (idx_mode_e'(idx_mode)),
    .idx        (enc_idx),
    .step       (step),
    .edge_id    (edge_id),
    .dir_q      (dir_fwd),
    .ld_zero    (ld_zero),
    .ld_max     (ld_max),
    .ld_init    (ld_init),
    .first_seen (first_idx_seen),
    .first_dir  (first_idx_dir)
  );

  qpos_count_core #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .step     (step),
    .ld_zero  (ld_zero),
    .ld_max   (ld_max),
    .ld_init  (ld_init),
    .pos_max  (pos_max),
    .pos_init (pos_init),
    .cnt      (pos_cnt),
    .dir      (dir_fwd)
  );

endmodule

// File: tb/tb_qpos_counter.sv
`timescale 1ns/1ps
module tb_qpos_counter;
  localparam int W = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, a, b, idx, mode;
  logic [W-1:0] pmax, pinit;
  logic [W-1:0] pos_cnt;
  logic dir_fwd, first_idx_seen, first_idx_dir, phase_err;

  qpos_counter #(.CNT_W(W)) dut (
    .clk(clk), .rst(rst), .enc_a(a), .enc_b(b), .enc_idx(idx),
    .idx_mode(mode), .pos_max(pmax), .pos_init(pinit),
    .pos_cnt(pos_cnt), .dir_fwd(dir_fwd), .first_idx_seen(first_idx_seen),
    .first_idx_dir(first_idx_dir), .phase_err(phase_err)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  int ph = 0;

  logic [1:0]   m_ab;
  logic [W-1:0] m_cnt;
  bit m_dir, m_first, m_fdir, m_perr, m_idxq;
  int m_fedge;

  function automatic logic [1:0] pos2ab(int p);
    case (p)
      0: return 2'b00;
      1: return 2'b01;
      2: return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  function automatic int ab2pos(logic [1:0] v);
    case (v)
      2'b00: return 0;
      2'b01: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  // Expected state after a clock edge, from the requirements.
  task automatic model_step();
    int pp, cp, d, eid;
    bit fwd, valid, evt, nd;
    if (rst) begin
      m_ab = {a, b}; m_cnt = '0; m_dir = 0; m_first = 0; m_fdir = 0;
      m_perr = 0; m_idxq = 0; m_fedge = 0;
      return;
    end
    pp = ab2pos(m_ab); cp = ab2pos({a, b});
    d = (cp - pp + 4) % 4;
    fwd = (d == 1); valid = (d == 1) || (d == 3);
    eid = fwd ? pp : cp;
    if (mode == 1'b0) evt = idx && valid && (!m_first || eid == m_fedge);
    else              evt = idx && !m_idxq;
    nd = valid ? fwd : m_dir;
    if (evt && !m_first) begin m_first = 1; m_fdir = nd; m_fedge = eid; end
    if (evt && mode) m_cnt = pinit;
    else if (evt) m_cnt = fwd ? '0 : pmax;
    else if (d == 1) m_cnt = (m_cnt == pmax) ? '0 : m_cnt + 1'b1;
    else if (d == 3) m_cnt = (m_cnt == '0) ? pmax : m_cnt - 1'b1;
    if (d == 2) m_perr = 1;
    m_dir = nd; m_ab = {a, b}; m_idxq = idx;
  endtask

  task automatic compare(string tag);
    chk(tag, "pos_cnt", pos_cnt, m_cnt);
    chk(tag, "dir_fwd", dir_fwd, m_dir);
    chk(tag, "first_idx_seen", first_idx_seen, m_first);
    chk(tag, "first_idx_dir", first_idx_dir, m_fdir);
    chk(tag, "phase_err", phase_err, m_perr);
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic tick(bit ix, string tag);
    {a, b} = pos2ab(ph);
    idx = ix;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic move(int s, bit ix, string tag);
    ph = (ph + s + 4) % 4;
    tick(ix, tag);
  endtask

  task automatic do_reset(bit md, int mx, int ini);
    mode = md; pmax = W'(mx); pinit = W'(ini); rst = 1'b1;
    tick(1'b0, "R1");
    tick(1'b0, "R1");
    rst = 1'b0;
    chk("R1", "reset count", pos_cnt, 0);
    chk("R1", "reset dir", dir_fwd, 0);
    chk("R1", "reset flags", {first_idx_seen, first_idx_dir, phase_err}, 0);
  endtask

  task automatic random_run(bit md, int n, string tag);
    int sdir = 1;
    bit ix = 0;
    for (int i = 0; i < n; i++) begin
      int r = int'($urandom_range(0, 99));
      if (int'($urandom_range(0, 9)) == 0) ix = ~ix;
      if (r < 15) sdir = -sdir;
      if (r < 3) move(2, ix, tag);
      else if (r < 15) tick(ix, tag);
      else move(sdir, ix, tag);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = int'($urandom(32'd4242));
    rst = 1'b1; a = 0; b = 0; idx = 0; mode = 0; pmax = '0; pinit = '0;
    @(negedge clk);

    // R2 / R3: counting and wrap, max = 5
    ph = 0;
    do_reset(1'b0, 5, 0);
    for (int i = 0; i < 8; i++) move(1, 1'b0, "R2");
    chk("R3", "wrap up count", pos_cnt, 2);
    chk("R2", "forward dir", dir_fwd, 1);
    for (int i = 0; i < 3; i++) move(-1, 1'b0, "R2");
    chk("R3", "wrap down count", pos_cnt, 5);
    chk("R2", "reverse dir", dir_fwd, 0);
    tick(1'b0, "R2");
    chk("R2", "idle hold", pos_cnt, 5);

    // R4: illegal double change
    move(2, 1'b0, "R4");
    chk("R4", "illegal count hold", pos_cnt, 5);
    chk("R4", "illegal dir hold", dir_fwd, 0);
    chk("R4", "phase_err set", phase_err, 1);
    move(1, 1'b0, "R4");
    chk("R4", "phase_err sticky", phase_err, 1);

    // R5 R7 R8 R9: reversal under a held index, max = 99
    ph = 0;
    do_reset(1'b0, 99, 0);
    for (int i = 0; i < 3; i++) move(1, 1'b0, "R2");
    move(1, 1'b1, "R5");
    chk("R5", "fwd index loads zero", pos_cnt, 0);
    chk("R7", "first seen", first_idx_seen, 1);
    chk("R7", "first dir fwd", first_idx_dir, 1);
    move(1, 1'b1, "R8");
    chk("R8", "other edge counts", pos_cnt, 1);
    move(-1, 1'b1, "R9");
    chk("R9", "reverse other edge", pos_cnt, 0);
    move(-1, 1'b1, "R9");
    chk("R9", "reverse over stored edge", pos_cnt, 99);
    move(-1, 1'b0, "R9");
    move(-1, 1'b0, "R9");
    move(1, 1'b0, "R9");
    chk("R9", "count continues", pos_cnt, 98);
    move(1, 1'b1, "R8");
    chk("R8", "non-stored edge under index", pos_cnt, 99);
    move(1, 1'b1, "R5");
    chk("R5", "stored edge reloads zero", pos_cnt, 0);

    // R6 R7: first event while reversing
    ph = 0;
    do_reset(1'b0, 99, 0);
    move(-1, 1'b0, "R3");
    move(-1, 1'b0, "R3");
    chk("R3", "down wrap", pos_cnt, 98);
    move(-1, 1'b1, "R6");
    chk("R6", "rev index loads max", pos_cnt, 99);
    chk("R7", "first dir rev", first_idx_dir, 0);

    // R10: initialization mode
    ph = 0;
    do_reset(1'b1, 5000, 1234);
    move(1, 1'b0, "R10");
    move(1, 1'b0, "R10");
    move(1, 1'b1, "R10");
    chk("R10", "rise loads init", pos_cnt, 1234);
    chk("R7", "first seen init mode", first_idx_seen, 1);
    move(1, 1'b1, "R10");
    chk("R10", "held index no reload", pos_cnt, 1235);
    move(1, 1'b0, "R10");
    tick(1'b1, "R10");
    chk("R10", "second rise loads init", pos_cnt, 1234);

    // Random walks against the model
    for (int s = 0; s < 4; s++) begin
      bit md = s[0];
      ph = int'($urandom_range(0, 3));
      do_reset(md, int'($urandom_range(6, 60)), int'($urandom_range(0, 500)));
      random_run(md, 2500, md ? "R10" : "R8");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule